// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block produces the two clocks of a stereo serial audio link when the link is the clock master. Both clocks are derived synchronously from a single master clock. The frame clock runs at the sample rate. The bit clock runs at 64 times the frame rate. A two-bit speed code sets how many master clock cycles make up one frame. A pre-divide enable can halve the master clock before the counters use it. This lets a faster master clock serve the same sample rate.

Both output clocks are registered bits taken from one frame-position counter. The frame clock is low for the left half of each frame and high for the right half. Its transitions line up with falling edges of the bit clock. A change to the speed code or to the pre-divide enable is accepted only at a frame boundary, so no frame is ever cut short or stretched. The one unused speed code is refused: it silences both clocks and raises an error flag until a valid code returns.

Top module: `audio_clk_master`

## Requirements
- R1: With the pre-divider off, the frame period is 512 master cycles for speed code 00 (single), 256 for 01 (double) and 128 for 10 (quad).
- R2: Every frame holds exactly 64 bit clock periods, and the bit clock has a 50 % duty cycle. Its period is therefore 8, 4 or 2 master cycles for codes 00, 01 and 10.
- R3: With prediv_en at 1, the counters advance only on every second master cycle, so every period given in R1 and R2 doubles.
- R4: fclk_o is 0 for the first half of each frame and 1 for the second half. It changes only in a cycle where bclk_o goes from 1 to 0.
- R5: While rst is high, bclk_o and fclk_o are 0. After release with code 00 and no pre-divide, bclk_o first rises 4 cycles later and fclk_o first rises 256 cycles later.
- R6: While the active code is 11, bclk_o and fclk_o stay at 0 and mode_err_o is 1. If code 11 is applied mid-frame, the clocks run on until the frame ends.
- R7: When the input leaves code 11, mode_err_o drops after one cycle and the counters restart from zero under the new code.
- R8: A new speed code takes effect only when the current frame completes; the frame in progress keeps its old length.
- R9: A new prediv_en value takes effect only when the current frame completes.
- R10: The speed code and prediv_en present during reset are active at once when reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| speed_sel | input | 2 | Speed code: 00 single, 01 double, 10 quad, 11 reserved |
| prediv_en | input | 1 | 1 halves the master clock before the counters |
| bclk_o | output | 1 | Serial bit clock, 64 periods per frame |
| fclk_o | output | 1 | Frame clock: low for the left half, high for the right half |
| mode_err_o | output | 1 | High while the reserved speed code is active |

## Verification
The wrap of the frame counter and the loading of a pending speed code or pre-divide setting happen in the same master cycle. In divided operation that cycle also carries a pre-divider tick. The bench changes speed_sel, and separately prediv_en, just after a frame clock rising edge, so the change waits half a frame before it may apply. It then measures the distance to the next frame clock fall under the old setting, and to the following rise under the new one. Entering the reserved code mid-frame is handled the same way. The bench counts the bit clock rises that still occur before the error flag rises, and checks the cycle in which the flag rises.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

    typedef enum logic [1:0] {
        SPD_SINGLE = 2'b00,
        SPD_DOUBLE = 2'b01,
        SPD_QUAD   = 2'b10,
        SPD_RSVD   = 2'b11
    } speed_e;

    // log2 of bit clock periods per frame (64)
    localparam int unsigned BIT_LOG2  = 6;
    // log2 of master ticks per frame in single speed (512)
    localparam int unsigned BASE_LOG2 = 9;
    localparam int unsigned CNT_W     = BASE_LOG2;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic bclk;
        logic fclk;
        logic err;
    } clk_out_t;

    // log2 of master ticks per frame for a valid speed
    function automatic int unsigned frame_log2(speed_e s);
        return BASE_LOG2 - int'(s);
    endfunction

    function automatic cnt_t last_pos(speed_e s);
        int unsigned fl;
        fl = (s == SPD_RSVD) ? BIT_LOG2 : frame_log2(s);
        return cnt_t'((1 << fl) - 1);
    endfunction

    // Map a frame position to the registered clock outputs
    function automatic clk_out_t decode(cnt_t c, speed_e s);
        clk_out_t    o;
        int unsigned fl;
        cnt_t        bsh;
        cnt_t        fsh;
        if (s == SPD_RSVD) begin
            o = '{bclk: 1'b0, fclk: 1'b0, err: 1'b1};
        end else begin
            fl     = frame_log2(s);
            bsh    = c >> (fl - BIT_LOG2 - 1);
            fsh    = c >> (fl - 1);
            o.bclk = bsh[0];
            o.fclk = fsh[0];
            o.err  = 1'b0;
        end
        return o;
    endfunction

endpackage

// File: rtl/aclk_mode_reg.sv
module aclk_mode_reg
    import aclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_in,
    input  logic       div_in,
    input  logic       boundary,
    output speed_e     mode_q,
    output speed_e     mode_n,
    output logic       div_q
);

    logic load;
    logic div_n;

    always_comb begin
        load   = rst || boundary;
        mode_n = load ? speed_e'(mode_in) : mode_q;
        div_n  = load ? div_in : div_q;
    end

    always_ff @(posedge clk) begin
        mode_q <= mode_n;
        div_q  <= div_n;
    end

    // R8: the active speed only moves after a frame boundary or reset
    a_r8_speed_waits_boundary: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode_q) |-> $past(boundary || rst));

    // R9: the active pre-divide setting only moves after a frame boundary or reset
    a_r9_div_waits_boundary: assert property (@(posedge clk) disable iff (rst)
        !$stable(div_q) |-> $past(boundary || rst));

endmodule

// File: rtl/aclk_prediv.sv
module aclk_prediv #(
    parameter int unsigned DIV_RATIO = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic div_q,
    input  logic restart,
    output logic tick
);

    localparam int unsigned PH_W = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV_RATIO - 1);

    logic [PH_W-1:0] ph;

    always_comb tick = !div_q || (ph == PH_LAST);

    always_ff @(posedge clk) begin
        if (rst || restart)
            ph <= '0;
        else if (div_q)
            ph <= (ph == PH_LAST) ? '0 : ph + 1'b1;
        else
            ph <= '0;
    end

    // R3: when dividing, two ticks never come in consecutive cycles
    a_r3_no_back_to_back_tick: assert property (@(posedge clk) disable iff (rst)
        (div_q && $past(div_q) && $past(tick) && !$past(rst)) |-> !tick);

endmodule

// File: rtl/aclk_frame_cnt.sv
module aclk_frame_cnt
    import aclk_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  speed_e mode_q,
    input  speed_e mode_n,
    output logic   boundary,
    output logic   bclk,
    output logic   fclk,
    output logic   err
);

    cnt_t     cnt;
    cnt_t     cnt_n;
    clk_out_t out_q;
    clk_out_t out_n;
    logic     rsvd;
    logic     wrap;

    always_comb begin
        rsvd     = (mode_q == SPD_RSVD);
        wrap     = tick && (cnt == last_pos(mode_q));
        boundary = rsvd || wrap;
        if (rst || boundary)
            cnt_n = '0;
        else if (tick)
            cnt_n = cnt + 1'b1;
        else
            cnt_n = cnt;
        out_n = decode(cnt_n, mode_n);
    end

    always_ff @(posedge clk) begin
        cnt   <= cnt_n;
        out_q <= out_n;
    end

    assign bclk = out_q.bclk;
    assign fclk = out_q.fclk;
    assign err  = out_q.err;

    // R4: the frame clock moves only together with a bit clock fall
    a_r4_frame_edge_on_bclk_fall: assert property (@(posedge clk) disable iff (rst)
        (!$stable(fclk) && !$past(rst)) |-> ($past(bclk) && !bclk));

    // R2: the frame position never passes the last slot of the active speed
    a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
        cnt <= last_pos(mode_q));

    // R6: while the reserved code is active the position stays parked at zero
    a_r6_reserved_parks_cnt: assert property (@(posedge clk) disable iff (rst)
        (mode_q == SPD_RSVD) |=> (cnt == '0));

endmodule

// File: rtl/audio_clk_master.sv
module audio_clk_master
    import aclk_pkg::*;
#(
    parameter int unsigned PREDIV_RATIO = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] speed_sel,
    input  logic       prediv_en,
    output logic       bclk_o,
    output logic       fclk_o,
    output logic       mode_err_o
);

    speed_e mode_q;
    speed_e mode_n;
    logic   div_q;
    logic   tick;
    logic   boundary;

    aclk_mode_reg u_mode (
        .clk      (clk),
        .rst      (rst),
        .mode_in  (speed_sel),
        .div_in   (prediv_en),
        .boundary (boundary),
        .mode_q   (mode_q),
        .mode_n   (mode_n),
        .div_q    (div_q)
    );

    aclk_prediv #(.DIV_RATIO(PREDIV_RATIO)) u_prediv (
        .clk     (clk),
        .rst     (rst),
        .div_q   (div_q),
        .restart (boundary),
        .tick    (tick)
    );

    aclk_frame_cnt u_frame (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .mode_q   (mode_q),
        .mode_n   (mode_n),
        .boundary (boundary),
        .bclk     (bclk_o),
        .fclk     (fclk_o),
        .err      (mode_err_o)
    );

    // R6: the error flag and a running clock never appear together
    a_r6_err_silences_clocks: assert property (@(posedge clk) disable iff (rst)
        mode_err_o |-> (!bclk_o && !fclk_o));

endmodule

// File: tb/test_audio_clk_master.sv
`timescale 1ns/1ps
module test_audio_clk_master;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] speed_sel = 2'b00;
    logic       prediv_en = 1'b0;
    logic       bclk, fclk, err;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    audio_clk_master i_audio_clk_master (
        .clk        (clk),
        .rst        (rst),
        .speed_sel  (speed_sel),
        .prediv_en  (prediv_en),
        .bclk_o     (bclk),
        .fclk_o     (fclk),
        .mode_err_o (err)
    );

    typedef struct packed {
        logic [1:0] m;
        logic       d;
        int         frame;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{m: 2'b00, d: 1'b0, frame: 512},
        '{m: 2'b01, d: 1'b0, frame: 256},
        '{m: 2'b10, d: 1'b0, frame: 128},
        '{m: 2'b00, d: 1'b1, frame: 1024},
        '{m: 2'b01, d: 1'b1, frame: 512},
        '{m: 2'b10, d: 1'b1, frame: 256}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] m, input logic d);
        speed_sel = m;
        prediv_en = d;
        rst = 1'b1;
        step();
        step();
        rst = 1'b0;
    endtask

    task automatic wait_fclk(input logic rise, output int n);
        logic pf;
        n = 0;
        forever begin
            pf = fclk;
            step();
            n++;
            if (rise ? (fclk && !pf) : (!fclk && pf)) break;
            if (n > 5000) break;
        end
    endtask

    task automatic wait_bclk_rise(output int n);
        logic pb;
        n = 0;
        forever begin
            pb = bclk;
            step();
            n++;
            if (bclk && !pb) break;
            if (n > 5000) break;
        end
    endtask

    // One frame, starting just after a frame clock rise
    task automatic measure(output int per, output int fhi, output int brise,
                           output int bhi, output int mis);
        logic pf, pb;
        per = 0; fhi = 0; brise = 0; bhi = 0; mis = 0;
        forever begin
            pf = fclk;
            pb = bclk;
            step();
            per++;
            if (fclk) fhi++;
            if (bclk) bhi++;
            if (bclk && !pb) brise++;
            if ((fclk != pf) && !(pb && !bclk)) mis++;
            if (fclk && !pf) break;
            if (per > 5000) break;
        end
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n, n2, per, fhi, brise, bhi, mis, bad;
        @(negedge clk);
        step();
        step();

        // R5: quiet outputs during reset
        chk("R5 bclk in reset", int'(bclk), 0);
        chk("R5 fclk in reset", int'(fclk), 0);
        chk("R5 err in reset", int'(err), 0);
        rst = 1'b0;
        wait_bclk_rise(n);
        chk("R5 first bclk rise", n, 4);
        wait_fclk(1'b1, n2);
        chk("R5 first fclk rise", n + n2, 256);

        // R1 R2 R3 R4: table walk over speeds and pre-divide
        for (int i = 0; i < 6; i++) begin
            do_reset(VECS[i].m, VECS[i].d);
            wait_fclk(1'b1, n);
            measure(per, fhi, brise, bhi, mis);
            chk(VECS[i].d ? "R3 frame period" : "R1 frame period", per, VECS[i].frame);
            chk("R4 fclk high half", fhi, VECS[i].frame / 2);
            chk("R2 bclk periods per frame", brise, 64);
            chk("R2 bclk duty", bhi, VECS[i].frame / 2);
            chk("R4 fclk edge on bclk fall", mis, 0);
            chk("R6 err clear in valid code", int'(err), 0);
        end

        // R10 R6: reserved code applied in reset
        do_reset(2'b11, 1'b0);
        chk("R10 err at once after reset", int'(err), 1);
        bad = 0;
        for (int k = 0; k < 100; k++) begin
            step();
            if (bclk || fclk || !err) bad++;
        end
        chk("R6 reserved holds clocks low", bad, 0);

        // R7: leave reserved for quad
        speed_sel = 2'b10;
        step();
        chk("R7 err drops", int'(err), 0);
        wait_bclk_rise(n);
        chk("R7 bclk restarts from zero", n, 1);
        wait_fclk(1'b1, n);
        chk("R7 fclk restarts from zero", n, 63);

        // R6: reserved entered mid-frame waits for the frame end
        speed_sel = 2'b11;
        n = 0; brise = 0;
        forever begin
            logic pb;
            pb = bclk;
            step();
            n++;
            if (bclk && !pb) brise++;
            if (err || n > 5000) break;
        end
        chk("R6 err at frame end", n, 64);
        chk("R6 bclk runs until frame end", brise, 32);
        chk("R6 clocks low with err", int'(bclk | fclk), 0);

        // R8: speed change mid-frame
        do_reset(2'b00, 1'b0);
        wait_fclk(1'b1, n);
        speed_sel = 2'b10;
        wait_fclk(1'b0, n);
        chk("R8 old frame kept", n, 256);
        wait_fclk(1'b1, n);
        chk("R8 new speed after boundary", n, 64);

        // R9: pre-divide change mid-frame
        do_reset(2'b10, 1'b0);
        wait_fclk(1'b1, n);
        prediv_en = 1'b1;
        wait_fclk(1'b0, n);
        chk("R9 old frame kept", n, 64);
        wait_fclk(1'b1, n);
        chk("R9 divided half frame", n, 128);
        measure(per, fhi, brise, bhi, mis);
        chk("R9 divided frame period", per, 256);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule